// File: doc/BRIEF.md
# Interrupt Pin Mode and Address-PROM Shadow Configuration

This block holds three configuration bits in a 16-bit register view: an LED program enable, an interrupt pin mode select and an address-PROM write enable. All other bit positions of that view are reserved and read as zero. The block also keeps a 16-byte shadow RAM. A serial configuration memory controller fills it byte by byte after power-up. Host accesses to the address-PROM space then read and write it. Host writes land only while the PROM write enable bit is set. The loader writes whatever the state of that bit.

The block drives the interrupt pad through two outputs: a pin value and an output enable for a tri-state driver. In level mode (mode bit 0) a pending interrupt pulls the pin low, and with nothing pending the driver is released so an external pull-up can raise the line. This lets several devices share the line. In edge mode (mode bit 1) the pin is always driven: high while an interrupt is pending, low otherwise. The pending input is sampled on the clock, and both pad outputs come straight from flops so they cannot glitch.

Hard reset (`rst_n`, synchronous, active low) clears everything. Soft reset and stop leave the configuration bits alone; their only effect is to abandon a load in progress. The load sequencer is a two-state machine:
- LD_IDLE: wait.
- LD_FILL: accept bytes at successive indices.

Its transitions are:
- START: LD_IDLE to LD_FILL on `ld_start`.
- FINISH: LD_FILL to LD_IDLE after the byte for the last index.
- ABORT: LD_FILL to LD_IDLE on `soft_rst` or `stop`.

Top module: `misc_cfg_irq`

## Requirements
- R1: While `rst_n` is low at a clock edge, the following are cleared after that edge: all three configuration bits, both pad outputs, `load_busy`, and every shadow RAM byte.
- R2: A clock edge with `cfg_wr` high copies `cfg_wdata` bit 12 (LED program enable), bit 8 (PROM write enable) and bit 7 (interrupt mode, 1 = edge) into the register. The new values appear on the same positions of `cfg_rdata` after that edge.
- R3: Every `cfg_rdata` bit other than 12, 8 and 7 reads 0, whatever was written.
- R4: `soft_rst` and `stop` leave the three configuration bits unchanged.
- R5: In level mode, one edge after `irq_pending` is sampled high the outputs are `irq_pin_oe`=1 and `irq_pin_o`=0. One edge after it is sampled low, `irq_pin_oe`=0.
- R6: In edge mode, `irq_pin_oe`=1 and `irq_pin_o` equals `irq_pending` as sampled at the previous edge.
- R7: The pad outputs change only at clock edges. They reflect the pending input and the mode bit as they stood just before that edge.
- R8: `ld_start` in LD_IDLE, with neither `soft_rst` nor `stop` high, raises `load_busy` after the edge. In LD_FILL, each edge with `ld_valid` writes `ld_data` at the next index, starting from 0, whatever the PROM write enable bit holds. After the write to index 15, `load_busy` falls.
- R9: In LD_FILL, `soft_rst` or `stop` drops `load_busy` after the edge and writes no byte at that edge. `ld_valid` in LD_IDLE writes nothing.
- R10: `prom_wr` with the PROM write enable bit at 1 and no load in progress writes `prom_wdata` at `prom_addr`.
- R11: `prom_wr` is ignored while the PROM write enable bit is 0 or while `load_busy` is 1.
- R12: `prom_rdata` returns, without a clock, the shadow RAM byte at `prom_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hard reset, synchronous, active low |
| soft_rst | input | 1 | Soft reset; aborts a load only |
| stop | input | 1 | Stop request; aborts a load only |
| cfg_wr | input | 1 | Configuration register write strobe |
| cfg_wdata | input | 16 | Configuration write data |
| cfg_rdata | output | 16 | Configuration register read view |
| prom_addr | input | 4 | Shadow RAM byte index for host access |
| prom_wr | input | 1 | Host shadow RAM write strobe |
| prom_wdata | input | 8 | Host shadow RAM write data |
| prom_rdata | output | 8 | Shadow RAM byte at `prom_addr` |
| ld_start | input | 1 | Loader begins a fill sequence |
| ld_valid | input | 1 | Loader byte valid |
| ld_data | input | 8 | Loader byte |
| load_busy | output | 1 | High while in LD_FILL |
| irq_pending | input | 1 | Internal interrupt pending |
| irq_pin_o | output | 1 | Interrupt pad output value |
| irq_pin_oe | output | 1 | Interrupt pad output enable |

## Verification
Several properties are checked on every cycle:
- The pad drive rules of both modes, one edge after sampling.
- The zero reserved bits.
- Configuration stability under soft reset or stop.
- The START and ABORT transitions.
- The landing or blocking of host writes at the addressed byte.

Other behaviour only the bench scenarios can show:
- The full sixteen-byte fill order.
- Which index each loader byte reaches, including after an ABORT and a fresh START.
- That idle loader strobes leave all bytes untouched.
- That hard reset clears RAM contents.

The bench shows these by comparing against its reference model on every clock while sweeping the read address.

// File: rtl/misc_cfg_pkg.sv
package misc_cfg_pkg;

    localparam int CFG_W      = 16;
    localparam int BIT_LEDEN  = 12;
    localparam int BIT_PROMWE = 8;
    localparam int BIT_EDGE   = 7;

    localparam logic [CFG_W-1:0] CFG_LIVE_MASK =
        (CFG_W'(1) << BIT_LEDEN) | (CFG_W'(1) << BIT_PROMWE) | (CFG_W'(1) << BIT_EDGE);

    typedef enum logic {
        LD_IDLE = 1'b0,
        LD_FILL = 1'b1
    } ld_state_e;

    typedef struct packed {
        logic led_prog_en;
        logic prom_wr_en;
        logic irq_edge_mode;
    } cfg_bits_t;

endpackage

// File: rtl/misc_cfg_reg.sv
module misc_cfg_reg
    import misc_cfg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [CFG_W-1:0] cfg_wdata,
    output cfg_bits_t        cfg_q,
    output logic [CFG_W-1:0] cfg_rdata
);

    logic unused_wdata;

    // Soft reset and stop are deliberately absent: only hard reset clears.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (cfg_wr) begin
            cfg_q.led_prog_en   <= cfg_wdata[BIT_LEDEN];
            cfg_q.prom_wr_en    <= cfg_wdata[BIT_PROMWE];
            cfg_q.irq_edge_mode <= cfg_wdata[BIT_EDGE];
        end
    end

    always_comb begin
        cfg_rdata             = '0;
        cfg_rdata[BIT_LEDEN]  = cfg_q.led_prog_en;
        cfg_rdata[BIT_PROMWE] = cfg_q.prom_wr_en;
        cfg_rdata[BIT_EDGE]   = cfg_q.irq_edge_mode;
    end

    assign unused_wdata = ^(cfg_wdata & ~CFG_LIVE_MASK);

endmodule

// File: rtl/misc_ld_seq.sv
module misc_ld_seq
    import misc_cfg_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          soft_rst,
    input  logic          stop,
    input  logic          ld_start,
    input  logic          ld_valid,
    output logic          busy,
    output logic          ld_we,
    output logic [AW-1:0] ld_idx
);

    ld_state_e     state_q, state_d;
    logic [AW-1:0] idx_q, idx_d;
    logic          abort;
    logic          last;

    assign abort = soft_rst | stop;
    assign last  = (idx_q == AW'(DEPTH - 1));

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LD_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    // Next state: START, FINISH, ABORT
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        unique case (state_q)
            LD_IDLE: begin
                if (ld_start && !abort) begin
                    state_d = LD_FILL;
                    idx_d   = '0;
                end
            end
            LD_FILL: begin
                if (abort) begin
                    state_d = LD_IDLE;
                end else if (ld_valid) begin
                    idx_d = idx_q + AW'(1);
                    if (last) begin
                        state_d = LD_IDLE;
                    end
                end
            end
            default: state_d = LD_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        busy   = 1'b0;
        ld_we  = 1'b0;
        ld_idx = idx_q;
        unique case (state_q)
            LD_IDLE: busy = 1'b0;
            LD_FILL: begin
                busy  = 1'b1;
                ld_we = ld_valid && !abort;
            end
            default: busy = 1'b0;
        endcase
    end

endmodule

// File: rtl/misc_shadow_ram.sv
module misc_shadow_ram #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_we,
    input  logic [AW-1:0] ld_idx,
    input  logic [DW-1:0] ld_data,
    input  logic          host_we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] rd_data
);

    logic [DW-1:0] mem_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_byte
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem_q[g] <= '0;
            end else if (ld_we && (ld_idx == AW'(g))) begin
                mem_q[g] <= ld_data;
            end else if (host_we && (addr == AW'(g))) begin
                mem_q[g] <= host_wdata;
            end
        end
    end

    assign rd_data = mem_q[addr];

endmodule

// File: rtl/misc_irq_drive.sv
module misc_irq_drive (
    input  logic clk,
    input  logic rst_n,
    input  logic pending,
    input  logic edge_mode,
    output logic pin_o,
    output logic pin_oe
);

    logic o_d, oe_d;

    always_comb begin
        if (edge_mode) begin
            oe_d = 1'b1;
            o_d  = pending;
        end else begin
            oe_d = pending;
            o_d  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_o  <= 1'b0;
            pin_oe <= 1'b0;
        end else begin
            pin_o  <= o_d;
            pin_oe <= oe_d;
        end
    end

endmodule

// File: rtl/misc_cfg_irq.sv
module misc_cfg_irq
    import misc_cfg_pkg::*;
#(
    parameter int ROM_BYTES = 16,
    parameter int BYTE_W    = 8,
    localparam int AW       = $clog2(ROM_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              stop,
    input  logic              cfg_wr,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic [CFG_W-1:0]  cfg_rdata,
    input  logic [AW-1:0]     prom_addr,
    input  logic              prom_wr,
    input  logic [BYTE_W-1:0] prom_wdata,
    output logic [BYTE_W-1:0] prom_rdata,
    input  logic              ld_start,
    input  logic              ld_valid,
    input  logic [BYTE_W-1:0] ld_data,
    output logic              load_busy,
    input  logic              irq_pending,
    output logic              irq_pin_o,
    output logic              irq_pin_oe
);

    cfg_bits_t     cfg_q;
    logic          ld_we;
    logic [AW-1:0] ld_idx;
    logic          host_we;

    misc_cfg_reg u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_wdata (cfg_wdata),
        .cfg_q     (cfg_q),
        .cfg_rdata (cfg_rdata)
    );

    misc_ld_seq #(.DEPTH(ROM_BYTES)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .stop     (stop),
        .ld_start (ld_start),
        .ld_valid (ld_valid),
        .busy     (load_busy),
        .ld_we    (ld_we),
        .ld_idx   (ld_idx)
    );

    assign host_we = prom_wr && cfg_q.prom_wr_en && !load_busy;

    misc_shadow_ram #(.DEPTH(ROM_BYTES), .DW(BYTE_W)) u_ram (
        .clk        (clk),
        .rst_n      (rst_n),
        .ld_we      (ld_we),
        .ld_idx     (ld_idx),
        .ld_data    (ld_data),
        .host_we    (host_we),
        .addr       (prom_addr),
        .host_wdata (prom_wdata),
        .rd_data    (prom_rdata)
    );

    misc_irq_drive u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .pending   (irq_pending),
        .edge_mode (cfg_q.irq_edge_mode),
        .pin_o     (irq_pin_o),
        .pin_oe    (irq_pin_oe)
    );

endmodule

// File: rtl/misc_cfg_irq_chk.sv
module misc_cfg_irq_chk
    import misc_cfg_pkg::*;
#(
    parameter int AW     = 4,
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              soft_rst,
    input logic              stop,
    input logic              cfg_wr,
    input logic [CFG_W-1:0]  cfg_rdata,
    input logic [AW-1:0]     prom_addr,
    input logic              prom_wr,
    input logic [BYTE_W-1:0] prom_wdata,
    input logic [BYTE_W-1:0] prom_rdata,
    input logic              ld_start,
    input logic              ld_valid,
    input logic              load_busy,
    input logic              irq_pending,
    input logic              irq_pin_o,
    input logic              irq_pin_oe
);

    p_level_drive_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pending && !cfg_rdata[BIT_EDGE]) |=> (irq_pin_oe && !irq_pin_o));

    p_level_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_pending && !cfg_rdata[BIT_EDGE]) |=> !irq_pin_oe);

    p_edge_drive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pending && cfg_rdata[BIT_EDGE]) |=> (irq_pin_oe && irq_pin_o));

    p_edge_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_pending && cfg_rdata[BIT_EDGE]) |=> (irq_pin_oe && !irq_pin_o));

    p_reserved_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata & ~CFG_LIVE_MASK) == '0);

    p_soft_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((soft_rst || stop) && !cfg_wr) |=> $stable(cfg_rdata));

    p_load_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_busy && ld_start && !soft_rst && !stop) |=> load_busy);

    p_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (load_busy && (soft_rst || stop)) |=> !load_busy);

    p_host_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (prom_wr && cfg_rdata[BIT_PROMWE] && !load_busy)
        |=> ((prom_addr != $past(prom_addr)) || (prom_rdata == $past(prom_wdata))));

    p_host_block_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (prom_wr && (!cfg_rdata[BIT_PROMWE] || load_busy) && !(load_busy && ld_valid))
        |=> ((prom_addr != $past(prom_addr)) || (prom_rdata == $past(prom_rdata))));

endmodule

bind misc_cfg_irq misc_cfg_irq_chk #(.AW(AW), .BYTE_W(BYTE_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .soft_rst    (soft_rst),
    .stop        (stop),
    .cfg_wr      (cfg_wr),
    .cfg_rdata   (cfg_rdata),
    .prom_addr   (prom_addr),
    .prom_wr     (prom_wr),
    .prom_wdata  (prom_wdata),
    .prom_rdata  (prom_rdata),
    .ld_start    (ld_start),
    .ld_valid    (ld_valid),
    .load_busy   (load_busy),
    .irq_pending (irq_pending),
    .irq_pin_o   (irq_pin_o),
    .irq_pin_oe  (irq_pin_oe)
);

// File: tb/misc_cfg_irq_test.sv
`timescale 1ns/1ps
module misc_cfg_irq_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_rst = 1'b0, stop = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic [3:0]  prom_addr = '0;
    logic        prom_wr = 1'b0;
    logic [7:0]  prom_wdata = '0;
    logic [7:0]  prom_rdata;
    logic        ld_start = 1'b0, ld_valid = 1'b0;
    logic [7:0]  ld_data = '0;
    logic        load_busy;
    logic        irq_pending = 1'b0;
    logic        irq_pin_o, irq_pin_oe;

    int checks = 0, failures = 0, cyc = 0;
    bit armed = 1'b0, done = 1'b0;

    always #2 clk = ~clk;

    misc_cfg_irq uut (.*);

    // Behavioural reference model
    logic [7:0] m_mem [16];
    bit m_led = 0, m_pwe = 0, m_edge = 0, m_busy = 0, m_o = 0, m_oe = 0;
    int m_idx = 0;

    always @(posedge clk) begin
        bit busy_old, pwe_old, edge_old;
        cyc++;
        armed = 1'b1;
        if (!rst_n) begin
            m_led = 0; m_pwe = 0; m_edge = 0; m_busy = 0; m_o = 0; m_oe = 0; m_idx = 0;
            foreach (m_mem[i]) m_mem[i] = 8'h00;
        end else begin
            busy_old = m_busy; pwe_old = m_pwe; edge_old = m_edge;
            m_oe = edge_old ? 1'b1 : irq_pending;
            m_o  = edge_old ? irq_pending : 1'b0;
            if (!busy_old) begin
                if (ld_start && !soft_rst && !stop) begin m_busy = 1; m_idx = 0; end
            end else if (soft_rst || stop) begin
                m_busy = 0;
            end else if (ld_valid) begin
                m_mem[m_idx] = ld_data;
                if (m_idx == 15) m_busy = 0;
                m_idx++;
            end
            if (prom_wr && pwe_old && !busy_old) m_mem[prom_addr] = prom_wdata;
            if (cfg_wr) begin
                m_led = cfg_wdata[12]; m_pwe = cfg_wdata[8]; m_edge = cfg_wdata[7];
            end
        end
    end

    task automatic chk(input bit ok, input string what, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    // Compare against the model on every clock, away from the edge
    always @(negedge clk) begin
        logic [15:0] exp_cfg;
        if (armed && !done) begin
            exp_cfg = '0;
            exp_cfg[12] = m_led; exp_cfg[8] = m_pwe; exp_cfg[7] = m_edge;
            chk(cfg_rdata === exp_cfg, "R2/R3/R4 cfg_rdata", cfg_rdata, exp_cfg);
            chk(prom_rdata === m_mem[prom_addr], "R10/R11/R12 prom_rdata", 16'(prom_rdata), 16'(m_mem[prom_addr]));
            chk(load_busy === m_busy, "R8/R9 load_busy", 16'(load_busy), 16'(m_busy));
            // R7: pad outputs registered, compared against model state updated at the edge
            chk(irq_pin_oe === m_oe, m_edge ? "R6 irq_pin_oe" : "R5 irq_pin_oe", 16'(irq_pin_oe), 16'(m_oe));
            chk(irq_pin_o === m_o, m_edge ? "R6 irq_pin_o" : "R5 irq_pin_o", 16'(irq_pin_o), 16'(m_o));
        end
    end

    always @(posedge clk) begin
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr_cfg(input logic [15:0] v);
        cfg_wr = 1; cfg_wdata = v; step(1); cfg_wr = 0; cfg_wdata = '0;
    endtask

    task automatic host_wr(input logic [3:0] a, input logic [7:0] d);
        prom_addr = a; prom_wr = 1; prom_wdata = d; step(1); prom_wr = 0;
    endtask

    task automatic sweep();
        for (int a = 0; a < 16; a++) begin prom_addr = 4'(a); step(1); end
    endtask

    initial begin
        step(3);
        // R1: reset state
        chk(cfg_rdata === 16'h0 && !load_busy && !irq_pin_oe && !irq_pin_o,
            "R1 reset outputs", {cfg_rdata[15:3], load_busy, irq_pin_oe, irq_pin_o}, 16'h0);
        rst_n = 1;
        step(1);
        // R5: level mode
        irq_pending = 1; step(2); irq_pending = 0; step(2);
        irq_pending = 1; step(1); irq_pending = 0; step(1);
        // R2/R3: all ones written, only live bits read back
        wr_cfg(16'hFFFF); step(1);
        chk(cfg_rdata === 16'h1180, "R3 reserved bits", cfg_rdata, 16'h1180);
        // R6: edge mode
        irq_pending = 1; step(2); irq_pending = 0; step(2); irq_pending = 1; step(1);
        // R7: mode change while pending
        wr_cfg(16'h1100); step(2); irq_pending = 0; step(1);
        // R4: soft reset and stop keep config
        soft_rst = 1; step(1); soft_rst = 0; stop = 1; step(2); stop = 0; step(1);
        chk(cfg_rdata === 16'h1100, "R4 config after soft reset/stop", cfg_rdata, 16'h1100);
        // R10: enabled host writes
        for (int a = 0; a < 16; a += 3) host_wr(4'(a), 8'(8'hA0 + a));
        sweep();
        // R11: disabled host writes
        wr_cfg(16'h0000);
        host_wr(4'd3, 8'h55); host_wr(4'd6, 8'h66);
        prom_addr = 4'd3; step(1);
        chk(prom_rdata === 8'hA3, "R11 blocked write", 16'(prom_rdata), 16'hA3);
        // R9: ld_valid in idle ignored
        ld_valid = 1; ld_data = 8'hEE; step(3); ld_valid = 0;
        // R8: full load with PROM write enable off, gaps between bytes
        ld_start = 1; step(1); ld_start = 0;
        for (int i = 0; i < 16; i++) begin
            ld_valid = 1; ld_data = 8'(8'h10 + i * 7); step(1);
            ld_valid = 0; if (i % 4 == 1) step(1);
        end
        step(1);
        sweep();
        // R11: host write during load ignored even with enable set
        wr_cfg(16'h0100);
        ld_start = 1; step(1); ld_start = 0;
        ld_valid = 1; ld_data = 8'hC1; step(1); ld_valid = 0;
        host_wr(4'd9, 8'h99);
        ld_valid = 1; ld_data = 8'hC2; step(1);
        // R9: abort mid-load with stop while a byte is offered
        stop = 1; ld_data = 8'hC3; step(1); stop = 0; ld_valid = 0;
        ld_valid = 1; ld_data = 8'hC4; step(2); ld_valid = 0;
        // R9: abort via soft reset after restart
        ld_start = 1; step(1); ld_start = 0;
        ld_valid = 1; ld_data = 8'hD0; step(1);
        soft_rst = 1; step(1); soft_rst = 0; ld_valid = 0;
        // R8: start ignored while soft reset high
        ld_start = 1; soft_rst = 1; step(1); ld_start = 0; soft_rst = 0; step(1);
        sweep();
        // R10: host write works again after load
        host_wr(4'd15, 8'h5A); prom_addr = 4'd15; step(1);
        chk(prom_rdata === 8'h5A, "R10 host write after load", 16'(prom_rdata), 16'h5A);
        // R1: hard reset mid-run clears RAM and config
        wr_cfg(16'h1080); irq_pending = 1; step(2);
        rst_n = 0; step(1); rst_n = 1; irq_pending = 0;
        chk(cfg_rdata === 16'h0 && prom_rdata === 8'h0, "R1 mid-run reset",
            {cfg_rdata[15:8], prom_rdata}, 16'h0);
        sweep();
        step(2);
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule